// File: doc/BRIEF.md
# PCIe Transmit Credit Gate

This block sits beside the transmit path of a PCIe endpoint and decides, one TLP at a time, whether the link partner has receive-buffer room for it. It keeps an advertised limit and a consumed count for each of six credit pools: a header pool and a data pool for each of the posted, non-posted and completion traffic kinds. The limits arrive on a sideband stream of typed update words. Each word carries an absolute limit value, not a delta. The consumed counts advance only when the block itself grants a TLP.

The transmit path presents a request with the TLP kind and its payload length in dwords. The grant output is combinational from the current state. When the request and the grant are both high at a clock edge, the TLP is taken as sent: one header credit and the needed data credits are charged to that kind. All arithmetic is modulo 2^16, so the counters may wrap freely.

Top module: `tx_credit_gate`

## Requirements
- R1: After reset every limit and every consumed count is 0, so no request is granted until updates arrive.
- R2: When `updValid` is high, `updData[15:0]` replaces the limit selected by `updData[18:16]`. The limit is absolute, not added. Class codes: 000 posted header, 001 non-posted header, 010 completion header, 100 posted data, 101 non-posted data, 110 completion data.
- R3: An update whose class code is 011 or 111 changes no limit.
- R4: An update word with `updValid` low changes no limit.
- R5: The data credits a TLP needs are ceil(`reqLenDw`/4), so one credit covers four dwords. A length of 0 needs no data credits.
- R6: `reqGrant` is high only when `reqValid` is high, (header limit − header consumed) mod 2^16 ≥ 1 and (data limit − data consumed) mod 2^16 ≥ the data credits needed, both for the requested kind.
- R7: On a clock edge with `reqValid` and `reqGrant` both high, the kind's header consumed count rises by 1 and its data consumed count rises by the credits needed, modulo 2^16.
- R8: When an update and a grant hit the same pool in one cycle, both take effect. The grant in that cycle uses the limit from before the update.
- R9: Each kind's pools are independent; credits of one kind never allow or charge a request of another. `reqKind` encoding: 00 posted, 01 non-posted, 10 completion.
- R10: A request with `reqKind` = 11 is never granted and charges nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| updValid | input | 1 | Update word valid; there is no back-pressure |
| updData | input | 19 | [18:16] class code, [15:0] limit value |
| reqValid | input | 1 | Transmit request present |
| reqKind | input | 2 | TLP kind of the request |
| reqLenDw | input | LEN_W | Payload length in dwords, 0 for none |
| reqGrant | output | 1 | Request may be sent now |

## Verification
Directed sequences first run the block from an empty state. They probe update words that must be ignored, a header pool drained one grant at a time, and length steps of 0, 1, 4, 5 and 8 dwords. These separate a correct round-up from a truncating divide, and a payload-free request from a one-credit one. Further cases put an update and a grant on the same pool in one cycle, which shows whether the old limit gates the grant and whether both writes survive. Other cases give one kind credits while another has none, which shows that the pools stay apart. A long random phase follows, with limits set just ahead of a bench-side consumed model and lengths up to the full field. It pushes the consumed counts through several 16-bit wraps and so exercises the modular availability compare.

// File: rtl/credit_gate_pkg.sv
`timescale 1ns/1ps
package credit_gate_pkg;
  localparam int CRED_W   = 16;
  localparam int CLASS_W  = 3;
  localparam int UPD_W    = CRED_W + CLASS_W;
  localparam int KIND_W   = 2;
  localparam int NUM_KIND = 3;
  localparam int DATA_BIT = UPD_W - 1;

  typedef struct packed {
    logic [NUM_KIND-1:0] hdrLimWe;
    logic [NUM_KIND-1:0] dataLimWe;
    logic [CRED_W-1:0]   limValue;
    logic [NUM_KIND-1:0] consume;
  } gateStrobes_t;

  typedef struct packed {
    logic [NUM_KIND-1:0] kindSel;
    logic [CRED_W-1:0]   needData;
  } reqInfo_t;
endpackage

// File: rtl/credit_pool.sv
`timescale 1ns/1ps
module credit_pool #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         limWe,
  input  logic [W-1:0] limValue,
  input  logic         useEn,
  input  logic [W-1:0] useAmt,
  output logic [W-1:0] avail
);
  logic [W-1:0] limitQ;
  logic [W-1:0] usedQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limitQ <= '0;
      usedQ  <= '0;
    end else begin
      if (limWe) limitQ <= limValue;
      if (useEn) usedQ  <= usedQ + useAmt;
    end
  end

  assign avail = limitQ - usedQ;
endmodule

// File: rtl/credit_gate_ctrl.sv
`timescale 1ns/1ps
module credit_gate_ctrl
  import credit_gate_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic              updValid,
  input  logic [UPD_W-1:0]  updData,
  input  logic              reqValid,
  input  logic [KIND_W-1:0] reqKind,
  input  logic [LEN_W-1:0]  reqLenDw,
  input  logic              fitOk,
  output gateStrobes_t      stb,
  output reqInfo_t          req,
  output logic              reqGrant
);
  localparam int PAD_W = LEN_W + 1;

  logic [KIND_W-1:0] updKind;
  logic              updIsData;
  logic [PAD_W-1:0]  lenPadded;

  assign updKind   = updData[CRED_W +: KIND_W];
  assign updIsData = updData[DATA_BIT];
  assign lenPadded = {1'b0, reqLenDw} + PAD_W'(3);

  always_comb begin
    for (int k = 0; k < NUM_KIND; k++) begin
      stb.hdrLimWe[k]  = updValid && !updIsData && (updKind == KIND_W'(k));
      stb.dataLimWe[k] = updValid &&  updIsData && (updKind == KIND_W'(k));
      req.kindSel[k]   = reqValid && (reqKind == KIND_W'(k));
    end
    stb.limValue = updData[CRED_W-1:0];
    req.needData = CRED_W'(lenPadded >> 2);
  end

  assign reqGrant    = (|req.kindSel) && fitOk;
  assign stb.consume = req.kindSel & {NUM_KIND{reqGrant}};
endmodule

// File: rtl/credit_gate_dp.sv
`timescale 1ns/1ps
module credit_gate_dp
  import credit_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  gateStrobes_t stb,
  input  reqInfo_t     req,
  output logic         fitOk
);
  logic [CRED_W-1:0]   hdrAvail  [NUM_KIND];
  logic [CRED_W-1:0]   dataAvail [NUM_KIND];
  logic [NUM_KIND-1:0] kindFits;

  for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
    credit_pool #(.W(CRED_W)) hdrPool (
      .clk      (clk),
      .rst_n    (rst_n),
      .limWe    (stb.hdrLimWe[k]),
      .limValue (stb.limValue),
      .useEn    (stb.consume[k]),
      .useAmt   (CRED_W'(1)),
      .avail    (hdrAvail[k])
    );
    credit_pool #(.W(CRED_W)) dataPool (
      .clk      (clk),
      .rst_n    (rst_n),
      .limWe    (stb.dataLimWe[k]),
      .limValue (stb.limValue),
      .useEn    (stb.consume[k]),
      .useAmt   (req.needData),
      .avail    (dataAvail[k])
    );
    assign kindFits[k] = req.kindSel[k] && (hdrAvail[k] != '0) &&
                         (dataAvail[k] >= req.needData);
  end

  assign fitOk = |kindFits;
endmodule

// File: rtl/tx_credit_gate.sv
`timescale 1ns/1ps
module tx_credit_gate
  import credit_gate_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              updValid,
  input  logic [UPD_W-1:0]  updData,
  input  logic              reqValid,
  input  logic [KIND_W-1:0] reqKind,
  input  logic [LEN_W-1:0]  reqLenDw,
  output logic              reqGrant
);
  gateStrobes_t stb;
  reqInfo_t     req;
  logic         fitOk;

  credit_gate_ctrl #(.LEN_W(LEN_W)) ctrl (
    .updValid (updValid),
    .updData  (updData),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .reqLenDw (reqLenDw),
    .fitOk    (fitOk),
    .stb      (stb),
    .req      (req),
    .reqGrant (reqGrant)
  );

  credit_gate_dp dp (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (stb),
    .req   (req),
    .fitOk (fitOk)
  );
endmodule

// File: rtl/tx_credit_gate_checker.sv
`timescale 1ns/1ps
module tx_credit_gate_checker
  import credit_gate_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              updValid,
  input logic [UPD_W-1:0]  updData,
  input logic              reqValid,
  input logic [KIND_W-1:0] reqKind,
  input logic              reqGrant
);
  // Set once any accepted header-class update has been seen since reset.
  logic hdrSeen;
  always_ff @(posedge clk) begin
    if (!rst_n) hdrSeen <= 1'b0;
    else if (updValid && !updData[DATA_BIT] && (updData[CRED_W +: KIND_W] != 2'b11))
      hdrSeen <= 1'b1;
  end

  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hdrSeen |-> !reqGrant);

  assert_grant_needs_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reqGrant |-> reqValid);

  assert_grant_known_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(reqGrant));

  assert_reserved_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqKind == 2'b11) |-> !reqGrant);
endmodule

bind tx_credit_gate tx_credit_gate_checker chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .updValid (updValid),
  .updData  (updData),
  .reqValid (reqValid),
  .reqKind  (reqKind),
  .reqGrant (reqGrant)
);

// File: tb/tx_credit_gate_test.sv
`timescale 1ns/1ps
module tx_credit_gate_test;
  localparam int LEN_W = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             updValid = 1'b0;
  logic [18:0]      updData = '0;
  logic             reqValid = 1'b0;
  logic [1:0]       reqKind = '0;
  logic [LEN_W-1:0] reqLenDw = '0;
  logic             reqGrant;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  logic [15:0] mLimH [3];
  logic [15:0] mUseH [3];
  logic [15:0] mLimD [3];
  logic [15:0] mUseD [3];

  always #2.5 clk = ~clk;

  tx_credit_gate #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .updValid(updValid), .updData(updData),
    .reqValid(reqValid), .reqKind(reqKind), .reqLenDw(reqLenDw), .reqGrant(reqGrant)
  );

  function automatic logic [15:0] needOf(int len);
    return 16'((len + 3) / 4);
  endfunction

  function automatic bit expGrant(int kind, int len);
    logic [15:0] aH, aD;
    if (kind > 2) return 1'b0;
    aH = mLimH[kind] - mUseH[kind];
    aD = mLimD[kind] - mUseD[kind];
    return (aH >= 16'd1) && (aD >= needOf(len));
  endfunction

  task automatic step(input bit uv, input logic [2:0] cls, input logic [15:0] val,
                      input bit rv, input logic [1:0] kind, input int len,
                      input string tag, input bit doCheck);
    bit exp;
    updValid = uv; updData = {cls, val};
    reqValid = rv; reqKind = kind; reqLenDw = LEN_W'(len);
    #1;
    exp = rv && expGrant(kind, len);
    if (doCheck) begin
      checks++;
      if (reqGrant !== exp) begin
        fails++;
        $display("FAIL %s: grant=%0b expected %0b (kind %0d len %0d)", tag, reqGrant, exp, kind, len);
      end
    end
    @(posedge clk);
    if (exp) begin
      mUseH[kind] = mUseH[kind] + 16'd1;
      mUseD[kind] = mUseD[kind] + needOf(len);
    end
    if (uv && cls[1:0] != 2'b11) begin
      if (cls[2]) mLimD[cls[1:0]] = val;
      else        mLimH[cls[1:0]] = val;
    end
    @(negedge clk);
  endtask

  task automatic setLim(input logic [2:0] cls, input logic [15:0] val);
    step(1'b1, cls, val, 1'b0, 2'd0, 0, "setup", 1'b0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      mLimH[k] = '0; mUseH[k] = '0; mLimD[k] = '0; mUseD[k] = '0;
    end
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    step(0, 3'b000, 16'd0, 1, 2'd0, 0, "R1", 1);
    step(0, 3'b010, 16'd0, 1, 2'd2, 0, "R1", 1);
    // R4: update without valid is ignored
    step(0, 3'b000, 16'd5, 1, 2'd0, 0, "R4", 1);
    step(0, 3'b000, 16'd0, 1, 2'd0, 0, "R4", 1);
    // R3: reserved class codes ignored
    setLim(3'b011, 16'd9);
    setLim(3'b111, 16'd9);
    step(0, 3'b000, 16'd0, 1, 2'd0, 0, "R3", 1);
    step(0, 3'b000, 16'd0, 1, 2'd1, 0, "R3", 1);
    // R8: same-cycle update gates on the old limit
    step(1, 3'b000, 16'd2, 1, 2'd0, 0, "R8", 1);
    // R2 then R7: two header credits drain one by one
    step(0, 3'b000, 16'd0, 1, 2'd0, 0, "R2", 1);
    step(0, 3'b000, 16'd0, 1, 2'd0, 0, "R7", 1);
    step(0, 3'b000, 16'd0, 1, 2'd0, 0, "R7", 1);
    // R5: data credit rounding
    setLim(3'b000, 16'd20);
    setLim(3'b100, 16'd1);
    step(0, 3'b000, 16'd0, 1, 2'd0, 4, "R5", 1);
    step(0, 3'b000, 16'd0, 1, 2'd0, 1, "R5", 1);
    setLim(3'b100, 16'd3);
    step(0, 3'b000, 16'd0, 1, 2'd0, 5, "R5", 1);
    step(0, 3'b000, 16'd0, 1, 2'd0, 0, "R5", 1);
    step(0, 3'b000, 16'd0, 1, 2'd0, 1, "R5", 1);
    // R8: grant and update on the same data pool
    step(1, 3'b100, 16'd9, 1, 2'd0, 8, "R8", 1);
    step(0, 3'b000, 16'd0, 1, 2'd0, 8, "R8", 1);
    step(0, 3'b000, 16'd0, 1, 2'd0, 1, "R8", 1);
    // R9: kinds independent
    step(0, 3'b000, 16'd0, 1, 2'd1, 0, "R9", 1);
    setLim(3'b010, 16'd1);
    step(0, 3'b000, 16'd0, 1, 2'd2, 0, "R9", 1);
    step(0, 3'b000, 16'd0, 1, 2'd1, 0, "R9", 1);
    step(0, 3'b000, 16'd0, 1, 2'd2, 0, "R9", 1);
    // R10: reserved kind never granted
    step(0, 3'b000, 16'd0, 1, 2'd3, 0, "R10", 1);
    step(0, 3'b000, 16'd0, 1, 2'd0, 0, "R10", 1);

    // R6 / R7: random phase with modular wrap
    for (int i = 0; i < 4000; i++) begin
      bit uv, rv;
      logic [2:0] cls;
      logic [15:0] val;
      logic [1:0] kind;
      int len;
      uv = ($urandom % 3) == 0;
      cls = 3'($urandom % 8);
      if (cls[1:0] == 2'b11) val = 16'($urandom);
      else if (cls[2]) val = mUseD[cls[1:0]] + 16'($urandom % 700);
      else val = mUseH[cls[1:0]] + 16'($urandom % 6);
      rv = ($urandom % 10) < 7;
      kind = 2'($urandom % 4);
      len = (($urandom % 4) == 0) ? 0 : int'($urandom % 2048);
      step(uv, cls, val, rv, kind, len, "R6", 1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule